// File: doc/BRIEF.md
# Smart-Card Interface Configuration and Status Register

This block is the host-side register file of a smart-card interface. A host drives an active-low strobe together with a mode line, a group line, a two-bit address and one data bit. The block samples these inputs while the strobe is low. When the strobe rises, a programming access commits one field. The fields are the card supply level, the card clock divide ratio, the card clock run/park control and the polarity of the card-detect switch. Each write code reaches only one field group, so the host can change one setting without rewriting the others.

With the mode line high, the access is a status read. The address picks one of four live status inputs and the block drives it onto a single status pin. The card-present status is corrected for the programmed switch polarity, so it reads 1 whenever a card is inserted. Supply generation and the clock divider sit outside this block; they consume the field outputs.

Top module: `cardif_cfg_regs`

## Requirements
- R1: After reset: `supply_hi`=0 (3.0 V), `clk_div`=00 (1/1), `clk_ctl`=00 (running) and `det_inv`=0 (normally-open switch).
- R2: Fields change only in the clock cycle where `strobe_n` is first seen high after being seen low. They hold steady for as long as the strobe stays low.
- R3: A commit with `rd_mode`=0 and `grp_hi`=0 sets `supply_hi`=`addr[1]` (1 = 5.0 V). It also sets `clk_div`={`addr[0]`,`dat`}, where 00=1/1, 01=1/2, 10=1/4 and 11=1/8.
- R4: A commit with `rd_mode`=0, `grp_hi`=1 and `addr[1]`=0 sets `clk_ctl`={`addr[0]`,`dat`}, where 00=run, 01=park low and 10=park high.
- R5: The code 11 for `clk_ctl` is reserved. A commit carrying it leaves `clk_ctl` unchanged.
- R6: A commit with `rd_mode`=0, `grp_hi`=1 and `addr[1]`=1 sets `det_inv`=0 when {`addr[0]`,`dat`}=00 (normally open). Any other value sets `det_inv`=1 (normally closed).
- R7: A write to one field group leaves the fields of the other groups unchanged.
- R8: While `strobe_n`=0 and `rd_mode`=1, `stat_out` follows the input picked by `addr`: 00 = `det_sw` XOR `det_inv` (card present), 01 = `boost_ok`, 10 = `batt_ok`, 11 = `supply_ok`.
- R9: `stat_out` is 1 whenever `strobe_n`=1 or `rd_mode`=0.
- R10: A status access (`rd_mode`=1) changes no field.
- R11: A commit uses the input values sampled in the last cycle the strobe was low. Values present when the strobe is seen high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_n | input | 1 | Active-low access strobe |
| rd_mode | input | 1 | 1 = status read, 0 = programming |
| grp_hi | input | 1 | Selects the field group during programming |
| addr | input | 2 | Field or status address |
| dat | input | 1 | Write data bit |
| det_sw | input | 1 | Raw card-detect switch level |
| boost_ok | input | 1 | DC-DC converter status |
| batt_ok | input | 1 | Battery status |
| supply_ok | input | 1 | Card supply status |
| supply_hi | output | 1 | Card supply select, 1 = 5.0 V |
| clk_div | output | 2 | Card clock divide ratio code |
| clk_ctl | output | 2 | Card clock run/park code |
| det_inv | output | 1 | Detect switch polarity, 1 = normally closed |
| stat_out | output | 1 | Status output |

## Verification
The hardest case is telling apart a commit that used the last sampled low-phase inputs from one that used the values present at the strobe edge. The bench handles this in two ways. At every strobe release it moves the address and data lines to a code that would write a different, visible value. It also holds the strobe low across several cycles while changing the code, then checks that only the final code lands. The reserved clock code is issued right after a park-high write, so that wrongly accepting it would show as a changed output.

// File: rtl/cardif_cfg_pkg.sv
package cardif_cfg_pkg;

  localparam int unsigned RATIO_W = 2;
  localparam int unsigned CTL_W   = 2;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned N_STAT  = 1 << ADDR_W;

  typedef enum logic [CTL_W-1:0] {
    CLK_RUN     = 2'b00,
    CLK_PARK_LO = 2'b01,
    CLK_PARK_HI = 2'b10,
    CLK_RSVD    = 2'b11
  } clk_ctl_e;

  typedef struct packed {
    logic              rd_mode;
    logic              grp_hi;
    logic [ADDR_W-1:0] addr;
    logic              dat;
  } acc_code_t;

  typedef struct packed {
    logic               supply_hi;
    logic [RATIO_W-1:0] clk_div;
    clk_ctl_e           clk_ctl;
    logic               det_inv;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{
    supply_hi: 1'b0,
    clk_div:   '0,
    clk_ctl:   CLK_RUN,
    det_inv:   1'b0
  };

endpackage

// File: rtl/cardif_access_capture.sv
module cardif_access_capture
  import cardif_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_n,
  input  acc_code_t code_in,
  output acc_code_t code_q,
  output logic      commit
);

  logic      strobe_q, strobe_d;
  acc_code_t code_d;
  logic      code_en;

  // Latch the code on every cycle the strobe is low; the last one wins.
  always_comb begin
    code_en  = ~strobe_n;
    code_d   = code_en ? code_in : code_q;
    strobe_d = strobe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      code_q   <= '0;
    end else begin
      strobe_q <= strobe_d;
      code_q   <= code_d;
    end
  end

  assign commit = strobe_n & ~strobe_q;

endmodule

// File: rtl/cardif_field_regs.sv
module cardif_field_regs
  import cardif_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit,
  input  acc_code_t code,
  output cfg_t      cfg
);

  logic           wr_any;
  logic           en_pwr, en_ctl, en_det;
  logic [CTL_W-1:0] pair;
  cfg_t           cfg_d;

  always_comb begin
    pair   = {code.addr[0], code.dat};
    wr_any = commit & ~code.rd_mode;
    en_pwr = wr_any & ~code.grp_hi;
    en_ctl = wr_any &  code.grp_hi & ~code.addr[1] & (clk_ctl_e'(pair) != CLK_RSVD);
    en_det = wr_any &  code.grp_hi &  code.addr[1];
  end

  always_comb begin
    cfg_d = cfg;
    if (en_pwr) begin
      cfg_d.supply_hi = code.addr[1];
      cfg_d.clk_div   = pair;
    end
    if (en_ctl) begin
      cfg_d.clk_ctl = clk_ctl_e'(pair);
    end
    if (en_det) begin
      cfg_d.det_inv = |pair;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else begin
      cfg <= cfg_d;
    end
  end

endmodule

// File: rtl/cardif_status_mux.sv
module cardif_status_mux
  import cardif_cfg_pkg::*;
#(
  parameter int unsigned SEL_W = ADDR_W,
  localparam int unsigned N    = 1 << SEL_W
) (
  input  logic [N-1:0]     stat_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             rd_en,
  output logic             stat_out
);

  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign hit[g] = rd_en & (sel == SEL_W'(g)) & stat_in[g];
  end

  // Idle level is high; a read drives the selected bit.
  assign stat_out = rd_en ? (|hit) : 1'b1;

endmodule

// File: rtl/cardif_cfg_regs.sv
module cardif_cfg_regs
  import cardif_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_n,
  input  logic               rd_mode,
  input  logic               grp_hi,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               dat,
  input  logic               det_sw,
  input  logic               boost_ok,
  input  logic               batt_ok,
  input  logic               supply_ok,
  output logic               supply_hi,
  output logic [RATIO_W-1:0] clk_div,
  output logic [CTL_W-1:0]   clk_ctl,
  output logic               det_inv,
  output logic               stat_out
);

  acc_code_t           code_in, code_q;
  logic                commit;
  cfg_t                cfg;
  logic [N_STAT-1:0]   stat_vec;
  logic                card_in;

  assign code_in = '{rd_mode: rd_mode, grp_hi: grp_hi, addr: addr, dat: dat};

  cardif_access_capture i_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (strobe_n),
    .code_in  (code_in),
    .code_q   (code_q),
    .commit   (commit)
  );

  cardif_field_regs i_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .code   (code_q),
    .cfg    (cfg)
  );

  assign card_in  = det_sw ^ cfg.det_inv;
  assign stat_vec = {supply_ok, batt_ok, boost_ok, card_in};

  cardif_status_mux #(.SEL_W(ADDR_W)) i_stat (
    .stat_in  (stat_vec),
    .sel      (addr),
    .rd_en    (~strobe_n & rd_mode),
    .stat_out (stat_out)
  );

  assign supply_hi = cfg.supply_hi;
  assign clk_div   = cfg.clk_div;
  assign clk_ctl   = cfg.clk_ctl;
  assign det_inv   = cfg.det_inv;

endmodule

// File: rtl/cardif_cfg_regs_chk.sv
module cardif_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_n,
  input logic       rd_mode,
  input logic       grp_hi,
  input logic [1:0] addr,
  input logic       dat,
  input logic       det_sw,
  input logic       supply_hi,
  input logic [1:0] clk_div,
  input logic [1:0] clk_ctl,
  input logic       det_inv,
  input logic       stat_out
);

  logic       seen_prev;
  logic       lo_rd, lo_grp, lo_dat;
  logic [1:0] lo_addr;
  logic       edge_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_prev <= 1'b1;
      lo_rd     <= 1'b0;
      lo_grp    <= 1'b0;
      lo_addr   <= 2'b00;
      lo_dat    <= 1'b0;
    end else begin
      seen_prev <= strobe_n;
      if (!strobe_n) begin
        lo_rd   <= rd_mode;
        lo_grp  <= grp_hi;
        lo_addr <= addr;
        lo_dat  <= dat;
      end
    end
  end

  assign edge_up = strobe_n & ~seen_prev;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_up |=> $stable({supply_hi, clk_div, clk_ctl, det_inv}));

  p_pwr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_up && !lo_rd && !lo_grp) |=>
      (clk_div == $past({lo_addr[0], lo_dat})) && (supply_hi == $past(lo_addr[1])));

  p_rsvd_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_up && !lo_rd && lo_grp && !lo_addr[1] && lo_addr[0] && lo_dat) |=> $stable(clk_ctl));

  p_det_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_up && !lo_rd && lo_grp && lo_addr[1]) |=> (det_inv == $past(lo_addr[0] | lo_dat)));

  p_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_up && lo_grp) |=> $stable({supply_hi, clk_div}));

  p_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_up && lo_rd) |=> $stable({supply_hi, clk_div, clk_ctl, det_inv}));

  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n || !rd_mode) |-> stat_out);

  p_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && rd_mode && addr == 2'b00) |-> (stat_out == (det_sw ^ det_inv)));

endmodule

bind cardif_cfg_regs cardif_cfg_regs_chk i_cardif_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strobe_n  (strobe_n),
  .rd_mode   (rd_mode),
  .grp_hi    (grp_hi),
  .addr      (addr),
  .dat       (dat),
  .det_sw    (det_sw),
  .supply_hi (supply_hi),
  .clk_div   (clk_div),
  .clk_ctl   (clk_ctl),
  .det_inv   (det_inv),
  .stat_out  (stat_out)
);

// File: tb/test_cardif_cfg_regs.sv
module test_cardif_cfg_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic       rd_mode = 1'b0, grp_hi = 1'b0, dat = 1'b0;
  logic [1:0] addr = 2'b00;
  logic       det_sw = 1'b1, boost_ok = 1'b0, batt_ok = 1'b0, supply_ok = 1'b0;
  logic       supply_hi, det_inv, stat_out;
  logic [1:0] clk_div, clk_ctl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cardif_cfg_regs i_cardif_cfg_regs (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .rd_mode(rd_mode),
    .grp_hi(grp_hi), .addr(addr), .dat(dat), .det_sw(det_sw),
    .boost_ok(boost_ok), .batt_ok(batt_ok), .supply_ok(supply_ok),
    .supply_hi(supply_hi), .clk_div(clk_div), .clk_ctl(clk_ctl),
    .det_inv(det_inv), .stat_out(stat_out)
  );

  // [10] rd_mode [9] grp_hi [8:7] addr [6] dat | [5] supply_hi [4:3] clk_div [2:1] clk_ctl [0] det_inv
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_11_0_1_10_00_0,  // R3 5.0 V, 1/4
    11'b0_1_00_1_1_10_01_0,  // R4 park low, R7
    11'b0_1_01_0_1_10_10_0,  // R4 park high
    11'b0_1_01_1_1_10_10_0,  // R5 reserved kept
    11'b0_1_10_1_1_10_10_1,  // R6 closed
    11'b0_1_10_0_1_10_10_0,  // R6 open
    11'b0_1_11_0_1_10_10_1,  // R6 closed
    11'b0_0_00_1_0_01_10_1,  // R3 3.0 V, 1/2, R7
    11'b1_0_11_0_0_01_10_1,  // R10 status read only
    11'b0_1_00_0_0_01_00_1,  // R4 run
    11'b0_0_01_1_0_11_00_1,  // R3 1/8
    11'b0_1_11_1_0_11_00_1   // R6 closed
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req, input logic [5:0] exp);
    chk(req, int'({supply_hi, clk_div, clk_ctl, det_inv}), int'(exp));
  endtask

  // One access: strobe low for one cycle, then released with decoy inputs (R11).
  task automatic access(input logic [4:0] c);
    @(negedge clk);
    strobe_n = 1'b0;
    {rd_mode, grp_hi, addr, dat} = c;
    @(negedge clk);
    strobe_n = 1'b1;
    {rd_mode, grp_hi, addr, dat} = 5'b0_0_10_0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] cur;
    repeat (3) @(negedge clk);
    chk_cfg("R1 reset in progress", 6'b0_00_00_0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_cfg("R1 reset defaults", 6'b0_00_00_0);
    chk("R9 idle status", int'(stat_out), 1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][10:6]);
      chk_cfg($sformatf("vector %0d R3/R4/R5/R6/R7/R10/R11", i), VEC[i][5:0]);
    end
    cur = VEC[NV-1][5:0];

    // R2 and R11: long low phase, code changes, only the last one lands.
    @(negedge clk);
    strobe_n = 1'b0;
    {rd_mode, grp_hi, addr, dat} = 5'b0_0_11_1_1;
    @(negedge clk);
    chk_cfg("R2 no change while strobe low", cur);
    chk("R9 status high in programming", int'(stat_out), 1);
    {rd_mode, grp_hi, addr, dat} = 5'b0_1_00_1;
    @(negedge clk);
    chk_cfg("R2 still held", cur);
    {rd_mode, grp_hi, addr, dat} = 5'b0_1_01_0;
    @(negedge clk);
    strobe_n = 1'b1;
    {rd_mode, grp_hi, addr, dat} = 5'b0_1_00_1;
    @(negedge clk);
    cur[2:1] = 2'b10;
    chk_cfg("R11 last low value committed", cur);

    // R8 status reads; det_inv is 1 here.
    det_sw = 1'b1; boost_ok = 1'b1; batt_ok = 1'b0; supply_ok = 1'b1;
    @(negedge clk);
    strobe_n = 1'b0; rd_mode = 1'b1; grp_hi = 1'b0;
    addr = 2'b00;
    #1 chk("R8 card absent, closed switch", int'(stat_out), 0);
    det_sw = 1'b0;
    #1 chk("R8 card present, closed switch", int'(stat_out), 1);
    addr = 2'b01;
    #1 chk("R8 boost status", int'(stat_out), 1);
    addr = 2'b10;
    #1 chk("R8 battery status", int'(stat_out), 0);
    addr = 2'b11; supply_ok = 1'b0;
    #1 chk("R8 supply status", int'(stat_out), 0);
    @(negedge clk);
    strobe_n = 1'b1; rd_mode = 1'b0;
    @(negedge clk);
    chk_cfg("R10 read left fields", cur);
    chk("R9 idle high after read", int'(stat_out), 1);

    // Back to normally open: card present follows switch directly (R6, R8).
    access(5'b0_1_10_0);
    chk("R6 open polarity", int'(det_inv), 0);
    det_sw = 1'b1;
    @(negedge clk);
    strobe_n = 1'b0; rd_mode = 1'b1; addr = 2'b00;
    #1 chk("R8 card present, open switch", int'(stat_out), 1);
    @(negedge clk);
    strobe_n = 1'b1; rd_mode = 1'b0;

    // R1: reset in the middle restores defaults.
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk_cfg("R1 async reset", 6'b0_00_00_0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_cfg("R1 defaults after reset", 6'b0_00_00_0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule